// File: doc/BRIEF.md
# Externally Clocked Code Word Readout

This block lets an external host pull a stored code word out of the device serially, using one of the button pins as the bit clock. The host signals that it wants a readout with a short sequence of pin levels. The block watches three button inputs and the bidirectional data pin through synchronisers. Once the sequence is complete and the host has let go of the data line, the block takes over the data pin as an output.

Each falling edge on the clocking button then puts the next bit of a frame on the data pin. The frame has three parts, in this order:
- an alternating preamble;
- a run of low header bits;
- the code word, least-significant bit first.

The code word is captured in parallel at the moment the block takes the pin. The device's auto-shutoff timeout stays in force throughout: a timeout pulse ends the readout at any point and returns the pin to the host.

Top module: `sync_readout`

## Requirements
- R1: After reset the data pin is released (`data_oe` = 0) and `data_out` is 0.
- R2: The block takes the pin (`data_oe` = 1) once all of the following have happened, in order: `pin_s2` high with `pin_s0`, `pin_s1` and the data pin low; then the data pin and either `pin_s0` or `pin_s1` high; then `pin_s2` and the data pin both low. When it takes the pin, `data_out` is 0.
- R3: During entry, `data_oe` stays 0 until the host has driven both `pin_s2` and the data pin low.
- R4: If `pin_s2` falls before the data pin and a button (`pin_s0` or `pin_s1`) are both high, entry is abandoned. A later data+button assertion without a fresh `pin_s2` rise does not take the pin.
- R5: The first PRE_LEN bits presented on `pin_s2` falling edges are a preamble alternating 1,0,1,0,… and starting with 1.
- R6: The next HDR_LEN bits are 0 (header).
- R7: The next CODE_W bits are `code_word` bits 0 upward, taken from the value present when the pin was taken. Later changes of `code_word` have no effect on the readout.
- R8: Falling edges of `pin_s2` after the last code bit keep `data_out` at 0 with the pin still driven while `pin_s0` or `pin_s1` is held. Releasing both buttons then releases the pin.
- R9: A `timeout` pulse while a readout is in progress releases the pin by the next cycle. Further `pin_s2` edges do not retake it.
- R10: `data_out` changes only on a falling edge of `pin_s2` (or when the pin is taken). A rising edge leaves it unchanged.
- R11: If a button is already high when `pin_s2` rises, that `pin_s2` high phase does not arm entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_s0 | input | 1 | Button input 0 (asynchronous) |
| pin_s1 | input | 1 | Button input 1 (asynchronous) |
| pin_s2 | input | 1 | Button input 2, serves as the readout clock (asynchronous) |
| pin_data_in | input | 1 | Level seen on the bidirectional data pin (asynchronous) |
| timeout | input | 1 | Auto-shutoff expiry pulse |
| code_word | input | CODE_W | Parallel code word to read out |
| data_out | output | 1 | Value driven onto the data pin |
| data_oe | output | 1 | Output enable of the data pin |

## Verification
The bench goes after the entry ordering:
- a detector that ignored the order would arm when a button was already high;
- a detector that never abandoned entry would take the pin after `pin_s2` dropped too early;
- a block that drove the pin before the host released it would collide with the host.

It checks every frame bit against a model under random code words and changes `code_word` mid-readout. An off-by-one in the bit count shows up as a shifted or lost bit. So does shifting on the rising edge, or loading the word late.

It fires the timeout at random bit positions and then clocks on. A design that kept shifting, or that retook the pin, would be caught. Edges past the last bit must read low, and button release must free the pin.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    parameter int CODE_W_DEF = 69;
    parameter int PRE_LEN_DEF = 8;
    parameter int HDR_LEN_DEF = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_ENTERED,
        ST_SHIFT,
        ST_DONE
    } rdo_state_e;

    typedef struct packed {
        logic s0;
        logic s1;
        logic s2;
        logic dat;
    } rdo_pins_t;

    function automatic logic btn_any(rdo_pins_t p);
        return p.s0 | p.s1;
    endfunction

    function automatic logic pre_bit(int k);
        return (k % 2) == 0;
    endfunction

endpackage

// File: rtl/rdo_sync.sv
module rdo_sync
    import rdo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rdo_pins_t raw,
    output rdo_pins_t synced,
    output logic      s2_fall
);
    localparam int W = $bits(rdo_pins_t);

    logic [W-1:0] raw_v;
    logic [W-1:0] sync_v;
    logic         s2_prev;

    assign raw_v  = raw;
    assign synced = sync_v;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic m1, m2;
            always_ff @(posedge clk) begin
                if (rst) begin
                    m1 <= 1'b0;
                    m2 <= 1'b0;
                end else begin
                    m1 <= raw_v[i];
                    m2 <= m1;
                end
            end
            assign sync_v[i] = m2;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) s2_prev <= 1'b0;
        else     s2_prev <= synced.s2;
    end

    assign s2_fall = s2_prev & ~synced.s2;

    // R10: a falling edge is flagged for a single cycle only
    a_r10_fall_single: assert property (@(posedge clk) disable iff (rst)
        s2_fall |=> !s2_fall);

endmodule

// File: rtl/rdo_ctrl.sv
module rdo_ctrl
    import rdo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rdo_pins_t synced,
    input  logic      s2_fall,
    input  logic      timeout,
    input  logic      frame_done,
    output logic      load,
    output logic      shift_en,
    output logic      oe
);
    rdo_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_IDLE:
                if (synced.s2 && !synced.dat && !btn_any(synced))
                    state_nx = ST_ARMED;
            ST_ARMED:
                if (!synced.s2)
                    state_nx = ST_IDLE;
                else if (synced.dat && btn_any(synced))
                    state_nx = ST_ENTERED;
            ST_ENTERED:
                if (!synced.s2 && !synced.dat) begin
                    state_nx = ST_SHIFT;
                    load     = !timeout;
                end
            ST_SHIFT:
                if (s2_fall && frame_done)
                    state_nx = ST_DONE;
            ST_DONE:
                if (!btn_any(synced))
                    state_nx = ST_IDLE;
            default:
                state_nx = ST_IDLE;
        endcase
        if (timeout)
            state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign oe       = (state == ST_SHIFT) || (state == ST_DONE);
    assign shift_en = oe && s2_fall && !timeout;

    // R4: dropping S2 while armed abandons entry
    a_r4_abort: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && !synced.s2) |=> state == ST_IDLE);

    // R9: a timeout always returns to idle
    a_r9_timeout_idle: assert property (@(posedge clk) disable iff (rst)
        timeout |=> state == ST_IDLE);

    // R3: pin is not taken while the host still drives data high
    a_r3_wait_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ENTERED && synced.dat) |=> !oe);

    // R11: arming needs buttons low when S2 is high
    a_r11_arm_order: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && btn_any(synced)) |=> state != ST_ARMED);

endmodule

// File: rtl/rdo_shifter.sv
module rdo_shifter #(
    parameter int CODE_W  = rdo_pkg::CODE_W_DEF,
    parameter int PRE_LEN = rdo_pkg::PRE_LEN_DEF,
    parameter int HDR_LEN = rdo_pkg::HDR_LEN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift_en,
    input  logic [CODE_W-1:0] code_word,
    output logic              dout,
    output logic              done
);
    localparam int TOTAL = CODE_W + PRE_LEN + HDR_LEN;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] LAST = CW'(TOTAL);

    logic [TOTAL-1:0] frame;
    logic [TOTAL-1:0] sreg;
    logic [CW-1:0]    cnt;

    generate
        for (genvar k = 0; k < PRE_LEN; k++) begin : g_pre
            assign frame[k] = rdo_pkg::pre_bit(k);
        end
        for (genvar k = 0; k < HDR_LEN; k++) begin : g_hdr
            assign frame[PRE_LEN + k] = 1'b0;
        end
        for (genvar j = 0; j < CODE_W; j++) begin : g_dat
            assign frame[PRE_LEN + HDR_LEN + j] = code_word[j];
        end
    endgenerate

    assign done = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            cnt  <= '0;
            dout <= 1'b0;
        end else if (load) begin
            sreg <= frame;
            cnt  <= '0;
            dout <= 1'b0;
        end else if (shift_en) begin
            if (!done) begin
                dout <= sreg[0];
                sreg <= sreg >> 1;
                cnt  <= cnt + 1'b1;
            end else begin
                dout <= 1'b0;
            end
        end
    end

    // R7: the bit counter never runs past the frame length
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R8: edges after the last bit present a low level
    a_r8_tail_low: assert property (@(posedge clk) disable iff (rst)
        (shift_en && done) |=> !dout);

    // R10: output only moves on a shift or load
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !load) |=> $stable(dout));

endmodule

// File: rtl/sync_readout.sv
module sync_readout #(
    parameter int CODE_W  = rdo_pkg::CODE_W_DEF,
    parameter int PRE_LEN = rdo_pkg::PRE_LEN_DEF,
    parameter int HDR_LEN = rdo_pkg::HDR_LEN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_s0,
    input  logic              pin_s1,
    input  logic              pin_s2,
    input  logic              pin_data_in,
    input  logic              timeout,
    input  logic [CODE_W-1:0] code_word,
    output logic              data_out,
    output logic              data_oe
);
    import rdo_pkg::*;

    rdo_pins_t raw, synced;
    logic      s2_fall, load, shift_en, frame_done;

    always_comb begin
        raw.s0  = pin_s0;
        raw.s1  = pin_s1;
        raw.s2  = pin_s2;
        raw.dat = pin_data_in;
    end

    rdo_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .raw     (raw),
        .synced  (synced),
        .s2_fall (s2_fall)
    );

    rdo_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .synced     (synced),
        .s2_fall    (s2_fall),
        .timeout    (timeout),
        .frame_done (frame_done),
        .load       (load),
        .shift_en   (shift_en),
        .oe         (data_oe)
    );

    rdo_shifter #(
        .CODE_W  (CODE_W),
        .PRE_LEN (PRE_LEN),
        .HDR_LEN (HDR_LEN)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .shift_en  (shift_en),
        .code_word (code_word),
        .dout      (data_out),
        .done      (frame_done)
    );

    // R3: the pin is only taken after the host released S2 and data
    a_r3_take_after_release: assert property (@(posedge clk) disable iff (rst)
        $rose(data_oe) |-> $past(!synced.s2 && !synced.dat));

    // R9: timeout releases the pin on the following cycle
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !data_oe);

endmodule

// File: tb/sync_readout_test.sv
module sync_readout_test;
    localparam int CODE_W  = 69;
    localparam int PRE_LEN = 8;
    localparam int HDR_LEN = 4;
    localparam int TOTAL   = CODE_W + PRE_LEN + HDR_LEN;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, host_dat = 1'b0, timeout = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic data_out, data_oe;
    logic pin_dat;

    assign pin_dat = data_oe ? data_out : host_dat;

    int checks = 0;
    int fails  = 0;

    sync_readout #(.CODE_W(CODE_W), .PRE_LEN(PRE_LEN), .HDR_LEN(HDR_LEN)) uut (
        .clk(clk), .rst(rst), .pin_s0(s0), .pin_s1(s1), .pin_s2(s2),
        .pin_data_in(pin_dat), .timeout(timeout), .code_word(code),
        .data_out(data_out), .data_oe(data_oe)
    );

    function automatic logic exp_bit(logic [CODE_W-1:0] w, int k);
        if (k < PRE_LEN)           return (k % 2) == 0;
        if (k < PRE_LEN + HDR_LEN) return 1'b0;
        return w[k - PRE_LEN - HDR_LEN];
    endfunction

    function automatic string region(int k);
        if (k < PRE_LEN)           return "R5 preamble";
        if (k < PRE_LEN + HDR_LEN) return "R6 header";
        return "R7 data";
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter(bit use_s1);
        s2 = 1'b1; wait_n(6);
        host_dat = 1'b1;
        if (use_s1) s1 = 1'b1; else s0 = 1'b1;
        wait_n(6);
        chk("R3 oe low while data high and s2 high", data_oe, 1'b0);
        s2 = 1'b0; wait_n(6);
        chk("R3 oe low while host still drives data", data_oe, 1'b0);
        host_dat = 1'b0; wait_n(6);
        chk("R2 pin taken after entry", data_oe, 1'b1);
        chk("R2 data low on entry", data_out, 1'b0);
    endtask

    task automatic pulse_check(int k, logic [CODE_W-1:0] w, logic prev);
        s2 = 1'b1; wait_n(5);
        chk("R10 rising edge holds data", data_out, prev);
        s2 = 1'b0; wait_n(5);
        chk(region(k), data_out, exp_bit(w, k));
    endtask

    task automatic readout(logic [CODE_W-1:0] w, bit use_s1);
        logic prev;
        code = w;
        enter(use_s1);
        code = ~w;
        prev = 1'b0;
        for (int k = 0; k < TOTAL; k++) begin
            pulse_check(k, w, prev);
            prev = exp_bit(w, k);
        end
        for (int t = 0; t < 2; t++) begin
            s2 = 1'b1; wait_n(5); s2 = 1'b0; wait_n(5);
            chk("R8 tail low", data_out, 1'b0);
            chk("R8 pin still driven", data_oe, 1'b1);
        end
        s0 = 1'b0; s1 = 1'b0; wait_n(6);
        chk("R8 release after buttons off", data_oe, 1'b0);
    endtask

    task automatic timeout_run(logic [CODE_W-1:0] w, int cut);
        logic prev;
        code = w;
        enter(cut[0]);
        prev = 1'b0;
        for (int k = 0; k < cut; k++) begin
            pulse_check(k, w, prev);
            prev = exp_bit(w, k);
        end
        @(negedge clk) timeout = 1'b1;
        @(negedge clk) timeout = 1'b0;
        chk("R9 pin released after timeout", data_oe, 1'b0);
        for (int t = 0; t < 3; t++) begin
            s2 = 1'b1; wait_n(5); s2 = 1'b0; wait_n(5);
            chk("R9 pin stays released", data_oe, 1'b0);
        end
        s0 = 1'b0; s1 = 1'b0; wait_n(6);
    endtask

    function automatic logic [CODE_W-1:0] rnd_word();
        logic [95:0] r;
        r = {$urandom(), $urandom(), $urandom()};
        return r[CODE_W-1:0];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h2c41_9e07));
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        chk("R1 oe after reset", data_oe, 1'b0);
        chk("R1 data after reset", data_out, 1'b0);

        // R4: s2 falls before data+button
        s2 = 1'b1; wait_n(6); s2 = 1'b0; wait_n(6);
        host_dat = 1'b1; s0 = 1'b1; wait_n(6);
        chk("R4 no entry after early s2 drop", data_oe, 1'b0);
        host_dat = 1'b0; wait_n(6);
        chk("R4 no entry after early s2 drop", data_oe, 1'b0);
        s0 = 1'b0; wait_n(6);

        // R11: button already high when s2 rises
        s1 = 1'b1; wait_n(6); s2 = 1'b1; wait_n(6);
        host_dat = 1'b1; wait_n(6);
        s2 = 1'b0; host_dat = 1'b0; wait_n(6);
        chk("R11 no arm with button high first", data_oe, 1'b0);
        s1 = 1'b0; wait_n(6);

        // directed words
        readout({CODE_W{1'b1}}, 1'b0);
        readout({{(CODE_W-1){1'b0}}, 1'b1}, 1'b1);

        for (int i = 0; i < 4; i++) readout(rnd_word(), i[0]);

        // timeouts at boundary and random positions
        timeout_run(rnd_word(), 0);
        timeout_run(rnd_word(), PRE_LEN + HDR_LEN + 1);
        for (int i = 0; i < 3; i++) timeout_run(rnd_word(), 1 + int'($urandom_range(TOTAL - 2)));

        // re-entry still works after timeouts
        readout(rnd_word(), 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule